// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block prepares the second operand of a data-processing datapath. It takes a 32-bit operand and moves it by up to 31 positions in one of four ways: left with zero fill, right with zero fill, right with sign fill, or rotation to the right. It also reports the single bit that last left the word, so that a later stage can update the carry flag. A separate mode treats the incoming carry flag and the operand together as a 33-bit word and rotates that word one place to the right.

The block is purely combinational. The result and the carry-out follow the inputs without any register. The caller selects the shift amount, which can come from an instruction field or from a register, and fetches the operand. A shift amount of zero leaves the operand untouched and passes the incoming carry straight through.

Top module: `opnd_shifter`

## Requirements
- R1: With the extend select low and a shift amount of 0, the result equals the operand for every kind, and the carry-out equals the incoming carry. When all inputs are zero, both outputs are zero.
- R2: Kind code 0 is a left shift by n (1 to 31). Zeros fill the n low bits, and the carry-out is operand bit 32-n.
- R3: Kind code 1 is a logical right shift by n. Zeros fill the n high bits, and the carry-out is operand bit n-1.
- R4: Kind code 2 is an arithmetic right shift by n. The n high bits are copies of operand bit 31, and the carry-out is operand bit n-1.
- R5: Kind code 3 rotates right by n. The bits that leave bit 0 re-enter at bit 31, and the carry-out is operand bit n-1, which equals result bit 31.
- R6: When the extend select is high, the kind and amount inputs are ignored. Result bit 31 is the incoming carry, result bits 30..0 are operand bits 31..1, and the carry-out is operand bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Operand to be shifted |
| kind_in | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| amt_in | input | 5 | Shift amount, 0 to 31 |
| rrx_in | input | 1 | Selects the 33-bit rotate through carry by one place |
| carry_in | input | 1 | Current carry flag |
| result_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Last bit shifted out, or carry_in when nothing moves |

## Verification
Both result_out and carry_out are due in the same cycle as the stimulus, because no register lies between any input and any output. The bench applies each input set just after a falling clock edge and samples 1 ns later, well clear of the next rising edge. Each comparison therefore sees only the settled response to one input set. The sweep covers every kind at every amount from 0 to 31 on corner and mixed operands. A reference model in the bench supplies the expected values, and separate table entries pin down the hand-computed corner results.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

    localparam int DATA_W = 32;
    localparam int AMT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SHK_LEFT  = 2'd0,
        SHK_LRIGHT = 2'd1,
        SHK_ARIGHT = 2'd2,
        SHK_ROTATE = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_e;

    typedef struct packed {
        logic  mirror;
        fill_e fill;
    } ladder_ctrl_t;

    function automatic ladder_ctrl_t decode_kind(shift_kind_e k);
        ladder_ctrl_t c;
        c.mirror = 1'b0;
        c.fill   = FILL_ZERO;
        case (k)
            SHK_LEFT:   begin c.mirror = 1'b1; c.fill = FILL_ZERO; end
            SHK_LRIGHT: begin c.mirror = 1'b0; c.fill = FILL_ZERO; end
            SHK_ARIGHT: begin c.mirror = 1'b0; c.fill = FILL_SIGN; end
            SHK_ROTATE: begin c.mirror = 1'b0; c.fill = FILL_WRAP; end
            default:    begin c.mirror = 1'b0; c.fill = FILL_ZERO; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/opnd_bit_flip.sv
module opnd_bit_flip #(
    parameter int WIDTH = opnd_shifter_pkg::DATA_W
) (
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign d_out[i] = d_in[WIDTH-1-i];
    end
endmodule

// File: rtl/opnd_right_ladder.sv
module opnd_right_ladder
    import opnd_shifter_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    localparam int SW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] d_in,
    input  logic [SW-1:0]    amt,
    input  fill_e            fill,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage [SW+1];
    logic             sign_bit;

    assign sign_bit = d_in[WIDTH-1];
    assign stage[0] = d_in;

    // Stage k moves the word right by 2**k when amount bit k is set.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [D-1:0] top_fill;
        always_comb begin
            case (fill)
                FILL_WRAP: top_fill = stage[k][D-1:0];
                FILL_SIGN: top_fill = {D{sign_bit}};
                default:   top_fill = '0;
            endcase
        end
        assign stage[k+1] = amt[k] ? {top_fill, stage[k][WIDTH-1:D]} : stage[k];
    end

    assign d_out = stage[SW];
endmodule

// File: rtl/opnd_carry_pick.sv
module opnd_carry_pick #(
    parameter int WIDTH = opnd_shifter_pkg::DATA_W,
    localparam int SW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] src,
    input  logic [SW-1:0]    amt,
    input  logic             carry_in,
    output logic             carry_out
);
    localparam logic [SW-1:0] ONE = SW'(1);
    logic [SW-1:0] last_idx;

    // The last bit to leave a right-moving word sits just below the amount.
    assign last_idx  = amt - ONE;
    assign carry_out = (amt == '0) ? carry_in : src[last_idx];
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opnd_shifter_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    localparam int SW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] op_in,
    input  logic [1:0]       kind_in,
    input  logic [SW-1:0]    amt_in,
    input  logic             rrx_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result_out,
    output logic             carry_out
);
    ladder_ctrl_t     ctrl;
    logic [WIDTH-1:0] op_rev;
    logic [WIDTH-1:0] ladder_src;
    logic [WIDTH-1:0] ladder_res;
    logic [WIDTH-1:0] ladder_rev;
    logic [WIDTH-1:0] shifted;
    logic             shift_carry;

    assign ctrl = decode_kind(shift_kind_e'(kind_in));

    // Left shifts run through the right ladder on a mirrored word.
    opnd_bit_flip #(.WIDTH(WIDTH)) u_flip_in (
        .d_in  (op_in),
        .d_out (op_rev)
    );

    assign ladder_src = ctrl.mirror ? op_rev : op_in;

    opnd_right_ladder #(.WIDTH(WIDTH)) u_ladder (
        .d_in  (ladder_src),
        .amt   (amt_in),
        .fill  (ctrl.fill),
        .d_out (ladder_res)
    );

    opnd_bit_flip #(.WIDTH(WIDTH)) u_flip_out (
        .d_in  (ladder_res),
        .d_out (ladder_rev)
    );

    assign shifted = ctrl.mirror ? ladder_rev : ladder_res;

    opnd_carry_pick #(.WIDTH(WIDTH)) u_carry (
        .src       (ladder_src),
        .amt       (amt_in),
        .carry_in  (carry_in),
        .carry_out (shift_carry)
    );

    // Rotate through carry overrides kind and amount.
    always_comb begin
        if (rrx_in) begin
            result_out = {carry_in, op_in[WIDTH-1:1]};
            carry_out  = op_in[0];
        end else begin
            result_out = shifted;
            carry_out  = shift_carry;
        end
    end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
    parameter int WIDTH = opnd_shifter_pkg::DATA_W,
    localparam int SW   = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] op_in,
    input logic [1:0]       kind_in,
    input logic [SW-1:0]    amt_in,
    input logic             rrx_in,
    input logic             carry_in,
    input logic [WIDTH-1:0] result_out,
    input logic             carry_out
);
    localparam logic [SW-1:0]    ONE  = SW'(1);
    localparam logic [SW-1:0]    ZERO = '0;
    localparam logic [WIDTH-1:0] ALL1 = '1;

    logic [SW-1:0] below_idx;
    logic [SW-1:0] left_idx;

    assign below_idx = amt_in - ONE;
    assign left_idx  = ZERO - amt_in;

    always_comb begin
        if (!$isunknown({op_in, kind_in, amt_in, rrx_in, carry_in, result_out, carry_out})) begin
            if (rrx_in) begin
                p_extend_rotate_r6: assert (result_out[WIDTH-1] == carry_in
                                            && result_out[WIDTH-2:0] == op_in[WIDTH-1:1]
                                            && carry_out == op_in[0])
                    else $error("R6 rotate through carry mismatch");
            end else if (amt_in == '0) begin
                p_zero_amount_passthru_r1: assert (result_out == op_in && carry_out == carry_in)
                    else $error("R1 zero-amount passthrough mismatch");
            end else begin
                case (kind_in)
                    2'd0: p_left_low_zero_r2: assert ((result_out & ~(ALL1 << amt_in)) == '0
                                                      && carry_out == op_in[left_idx])
                        else $error("R2 left shift fill or carry mismatch");
                    2'd1: p_lright_high_zero_r3: assert ((result_out & ~(ALL1 >> amt_in)) == '0
                                                         && carry_out == op_in[below_idx])
                        else $error("R3 logical right fill or carry mismatch");
                    2'd2: p_aright_sign_keep_r4: assert (result_out[WIDTH-1] == op_in[WIDTH-1]
                                                         && carry_out == op_in[below_idx])
                        else $error("R4 arithmetic right sign or carry mismatch");
                    default: p_rotate_bits_kept_r5: assert (carry_out == result_out[WIDTH-1]
                                                            && $countones(result_out) == $countones(op_in))
                        else $error("R5 rotate population or carry mismatch");
                endcase
            end
        end
    end
endmodule

bind opnd_shifter opnd_shifter_chk #(.WIDTH(WIDTH)) u_chk (
    .op_in      (op_in),
    .kind_in    (kind_in),
    .amt_in     (amt_in),
    .rrx_in     (rrx_in),
    .carry_in   (carry_in),
    .result_out (result_out),
    .carry_out  (carry_out)
);

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_in = '0;
    logic [1:0]  kind_in = '0;
    logic [4:0]  amt_in = '0;
    logic        rrx_in = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] result_out;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    opnd_shifter u_opnd_shifter (
        .op_in      (op_in),
        .kind_in    (kind_in),
        .amt_in     (amt_in),
        .rrx_in     (rrx_in),
        .carry_in   (carry_in),
        .result_out (result_out),
        .carry_out  (carry_out)
    );

    // {operand, kind, amount, extend, carry_in, expected result, expected carry}
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {32'h0000000C, 2'd0, 5'd2,  1'b0, 1'b0, 32'h00000030, 1'b0},
        {32'h80000001, 2'd0, 5'd1,  1'b0, 1'b0, 32'h00000002, 1'b1},
        {32'h00000001, 2'd0, 5'd31, 1'b0, 1'b1, 32'h80000000, 1'b0},
        {32'hF0000000, 2'd1, 5'd4,  1'b0, 1'b1, 32'h0F000000, 1'b0},
        {32'h00000018, 2'd1, 5'd4,  1'b0, 1'b0, 32'h00000001, 1'b1},
        {32'h80000000, 2'd1, 5'd31, 1'b0, 1'b1, 32'h00000001, 1'b0},
        {32'h80000000, 2'd2, 5'd31, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b0},
        {32'h7FFFFFFF, 2'd2, 5'd1,  1'b0, 1'b0, 32'h3FFFFFFF, 1'b1},
        {32'h12345678, 2'd3, 5'd8,  1'b0, 1'b1, 32'h78123456, 1'b0},
        {32'h000000F1, 2'd3, 5'd4,  1'b0, 1'b1, 32'h1000000F, 1'b0},
        {32'hFFFFFFFF, 2'd3, 5'd31, 1'b0, 1'b0, 32'hFFFFFFFF, 1'b1},
        {32'hDEADBEEF, 2'd1, 5'd0,  1'b0, 1'b1, 32'hDEADBEEF, 1'b1},
        {32'h00000003, 2'd0, 5'd5,  1'b1, 1'b1, 32'h80000001, 1'b1},
        {32'h00000002, 2'd3, 5'd31, 1'b1, 1'b0, 32'h00000001, 1'b0}
    };

    function automatic string req_of(logic [1:0] k, logic [4:0] n, logic r);
        if (r) return "R6";
        if (n == 0) return "R1";
        case (k)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Independent model: returns {carry, result}.
    function automatic logic [32:0] model(logic [31:0] v, logic [1:0] k, logic [4:0] n,
                                          logic r, logic c);
        logic [32:0]        t;
        logic signed [32:0] ts;
        logic [63:0]        w;
        if (r) return {v[0], c, v[31:1]};
        if (n == 0) return {c, v};
        case (k)
            2'd0: begin t = {1'b0, v} << n; return {t[32], t[31:0]}; end
            2'd1: begin t = {v, 1'b0} >> n; return {t[0], t[32:1]}; end
            2'd2: begin ts = {v, 1'b0}; ts = ts >>> n; return {ts[0], ts[32:1]}; end
            default: begin w = {v, v} >> n; return {w[31], w[31:0]}; end
        endcase
    endfunction

    task automatic apply_and_check(string req, logic [31:0] v, logic [1:0] k, logic [4:0] n,
                                   logic r, logic c, logic [31:0] exp_res, logic exp_c);
        @(negedge clk);
        op_in = v; kind_in = k; amt_in = n; rrx_in = r; carry_in = c;
        #1;
        n_checks++;
        if (result_out !== exp_res || carry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s op=%h kind=%0d amt=%0d ext=%0b cin=%0b: got %h/%0b expected %h/%0b",
                     req, v, k, n, r, c, result_out, carry_out, exp_res, exp_c);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: idle inputs after reset give zero result and zero carry
        apply_and_check("R1", 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] e;
            e = VEC[i];
            apply_and_check(req_of(e[41:40], e[39:35], e[34]),
                            e[73:42], e[41:40], e[39:35], e[34], e[33], e[32:1], e[0]);
        end

        // R1: zero amount for every kind with both carry values
        for (int k = 0; k < 4; k++) begin
            apply_and_check("R1", 32'hA5A5_0F0F, 2'(k), 5'd0, 1'b0, 1'b1, 32'hA5A5_0F0F, 1'b1);
            apply_and_check("R1", 32'h5A5A_F0F0, 2'(k), 5'd0, 1'b0, 1'b0, 32'h5A5A_F0F0, 1'b0);
        end

        // R2..R5 sweep every kind and amount over corner and mixed operands
        for (int vi = 0; vi < 6; vi++) begin
            logic [31:0] v;
            case (vi)
                0: v = 32'h80000000;
                1: v = 32'hFFFFFFFF;
                2: v = 32'h00000001;
                3: v = 32'h9E3779B9;
                4: v = 32'h5555AAAA;
                default: v = 32'h0F1E2D3C;
            endcase
            for (int k = 0; k < 4; k++) begin
                for (int n = 0; n < 32; n++) begin
                    logic [32:0] m;
                    logic        c;
                    c = 1'(vi + n);
                    m = model(v, 2'(k), 5'(n), 1'b0, c);
                    apply_and_check(req_of(2'(k), 5'(n), 1'b0), v, 2'(k), 5'(n), 1'b0, c,
                                    m[31:0], m[32]);
                end
            end
        end

        // R6: extend select ignores kind and amount
        for (int k = 0; k < 4; k++) begin
            apply_and_check("R6", 32'h80000001, 2'(k), 5'(7 * k + 3), 1'b1, 1'b0, 32'h40000000, 1'b1);
            apply_and_check("R6", 32'hFFFFFFFE, 2'(k), 5'(31 - k), 1'b1, 1'b1, 32'hFFFFFFFF, 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule